// File: doc/BRIEF.md
# Three-Source Divided Clock Selector Bank

This block drives a bank of clock output channels. Every channel can run from any of three source clocks. Each source has its own programmable integer divider for each channel. A two-bit select code per channel picks the source, and one code value gates the output off. The source clocks are slower than the block clock. They are brought in through two-flop synchronisers, and every divider, handover and status path runs in the block clock domain. Each output is therefore a registered waveform sampled at the block clock.

Software programs the divider words through a small register port and moves channels with a command port. A command can name a source or request switch-off. A change of source while a channel is running goes through a two-phase handover. The handover first lets the old divided clock fall low. It then holds the output low until the new divided clock is low, and only then applies the new source. One status word per source shows which channels are running on that source and have toggled since the last change. Software polls these words to confirm that a change has taken effect.

Top module: `tri_src_clk_bank`

## Requirements
- R1: After reset every channel select field reads 3 (off), every divider field reads 0, every status word reads 0 and every channel output is low.
- R2: Channel c's select field occupies bits p+1:p of select word 0 (address 0) with p = SEL_LSB + 2c when p < 32. Otherwise it occupies bits p-31:p-32 of select word 1 (address 1). With defaults (14 channels, SEL_LSB = 8), channel 11 sits at word 0 bits 31:30 and channels 12 and 13 at word 1 bits 1:0 and 3:2.
- R3: The divider field for source s and channel c is a 5-bit value at address 16 + 16s + c, held in bits 4:0. Bits 31:5 read 0. Writes to channel slots at or above NCH are ignored and those slots read 0.
- R4: A channel running on source s with divider field f has an output period of exactly (f+1) times the period of source s.
- R5: The output high time is floor((f+1)/2) source periods for f > 0. For f = 0 it equals the source high time.
- R6: A command with off = 0 and source code 3 leaves the select field unchanged, and the running channel keeps its output.
- R7: A command with off = 1 writes code 3 into the field. The output stays low and the channel's status bits clear.
- R8: Status word for source s is at address 2 + s. Bit FB_LSB + c of that word is 1 only while channel c has its source applied, that source is s, and its output has risen at least once since the change. With defaults FB_LSB = 4.
- R9: A source change on a running channel clears the old source's status bit. It applies the new source, and the new source's status bit sets again with the new period.
- R10: Across any sequence of changes the output never shows a high pulse shorter than the shortest source half-period. The applied source changes only while the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 3 | Three source clocks, asynchronous to clk |
| cmd_valid | input | 1 | Channel command strobe |
| cmd_ch | input | $clog2(NCH) | Channel addressed by the command |
| cmd_off | input | 1 | 1 requests switch-off |
| cmd_src | input | 2 | Requested source code when cmd_off is 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ch_clk | output | NCH | Channel clock outputs |

## Verification
The assertions assume that each source clock is a square wave whose high and low phases last at least two block clocks. Under that condition the synchroniser delivers clean single-cycle edges and a divided path never changes between them. They also assume that commands and register writes are single-cycle strobes. The bench drives the three sources as free-running square waves with periods of 4, 6 and 10 block clocks, with edges placed away from the clock edge. It issues every strobe for exactly one cycle. It sweeps all 32 divider values on each source, then runs a burst of back-to-back source changes and switch-offs to exercise the handover.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int NSRC  = 3;
  localparam int SEL_W = 2;
  localparam int DIV_W = 5;
  localparam logic [SEL_W-1:0] SEL_OFF = 2'd3;

  typedef enum logic [1:0] {ST_RUN, ST_OLD, ST_NEW} hand_t;

  // Number of source rising edges the output stays high (f > 0)
  function automatic logic [DIV_W:0] high_edges(input logic [DIV_W-1:0] f);
    return ({1'b0, f} + 1'b1) >> 1;
  endfunction

  // Next divider count, wrapping after f
  function automatic logic [DIV_W-1:0] next_count(input logic [DIV_W-1:0] c,
                                                  input logic [DIV_W-1:0] f);
    return (c >= f) ? '0 : c + 1'b1;
  endfunction

  // Absolute bit position of a channel's select field
  function automatic int sel_pos(input int lsb, input int ch);
    return lsb + SEL_W * ch;
  endfunction
endpackage

// File: rtl/tcb_sync.sv
module tcb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/tcb_divider.sv
module tcb_divider
  import tcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic [DIV_W-1:0] field,
  output logic             div_out
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_n;

  assign cnt_n = next_count(cnt, field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_out <= 1'b0;
    end else if (rise) begin
      cnt     <= cnt_n;
      div_out <= (field == '0) ? 1'b1 : ({1'b0, cnt_n} < high_edges(field));
    end else if (fall && field == '0) begin
      div_out <= 1'b0;
    end
  end

  // The divided path moves only on a synchronised source edge
  assert_div_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !fall) |=> $stable(div_out));
endmodule

// File: rtl/tcb_channel.sv
module tcb_channel
  import tcb_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             rise,
  input  logic [NSRC-1:0]             fall,
  input  logic [NSRC-1:0][DIV_W-1:0]  fields,
  input  logic [SEL_W-1:0]            target,
  output logic                        ch_out,
  output logic [NSRC-1:0]             run
);
  logic [NSRC-1:0]  path;
  hand_t            state;
  logic [SEL_W-1:0] cur;
  logic             seen, out_prev;
  logic             old_lvl, new_lvl, out_rise;

  for (genvar s = 0; s < NSRC; s++) begin : g_div
    tcb_divider u_div (
      .clk(clk), .rst_n(rst_n), .rise(rise[s]), .fall(fall[s]),
      .field(fields[s]), .div_out(path[s])
    );
  end

  assign old_lvl  = (cur != SEL_OFF) && path[cur];
  assign new_lvl  = (target != SEL_OFF) && path[target];
  assign ch_out   = (state != ST_NEW) && (cur != SEL_OFF) && path[cur];
  assign out_rise = ch_out && !out_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      cur      <= SEL_OFF;
      seen     <= 1'b0;
      out_prev <= 1'b0;
    end else begin
      out_prev <= ch_out;
      case (state)
        ST_RUN: if (target != cur) state <= ST_OLD;
        ST_OLD: if (!old_lvl) state <= ST_NEW;
        default: if (!new_lvl) begin
          cur   <= target;
          state <= ST_RUN;
        end
      endcase
      if (state == ST_NEW && !new_lvl) seen <= 1'b0;
      else if (out_rise)               seen <= 1'b1;
    end
  end

  always_comb begin
    for (int s = 0; s < NSRC; s++)
      run[s] = (state == ST_RUN) && (cur == SEL_W'(s)) && seen;
  end

  // Applied source changes only while the output is low
  assert_switch_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> !$past(ch_out));
  // At most one source reports running for a channel
  assert_run_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run));
  // Running is reported only after an output rise
  assert_run_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|run) |-> $past(ch_out));
endmodule

// File: rtl/tri_src_clk_bank.sv
module tri_src_clk_bank
  import tcb_pkg::*;
#(
  parameter int NCH     = 14,
  parameter int SEL_LSB = 8,
  parameter int FB_LSB  = 4,
  localparam int CH_W   = $clog2(NCH),
  localparam int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              cmd_valid,
  input  logic [CH_W-1:0]   cmd_ch,
  input  logic              cmd_off,
  input  logic [SEL_W-1:0]  cmd_src,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    ch_clk
);
  localparam int SLOT_W = 4;

  logic [NSRC-1:0]                      s_rise, s_fall;
  logic [NCH-1:0][SEL_W-1:0]            sel_q;
  logic [NSRC-1:0][NCH-1:0][DIV_W-1:0]  div_q;
  logic [NCH-1:0][NSRC-1:0][DIV_W-1:0]  ch_fields;
  logic [NCH-1:0][NSRC-1:0]             run_m;
  logic [NSRC-1:0][31:0]                fb_w;
  logic [31:0]                          sel_w0, sel_w1;
  logic [1:0]                           rg_src;
  logic [SLOT_W-1:0]                    rg_ch;
  logic                                 rg_div;
  logic                                 unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[31:DIV_W];
  assign rg_div = reg_addr[ADDR_W-1:SLOT_W] != 2'd0;
  assign rg_src = reg_addr[ADDR_W-1:SLOT_W] - 2'd1;
  assign rg_ch  = reg_addr[SLOT_W-1:0];

  for (genvar s = 0; s < NSRC; s++) begin : g_sync
    tcb_sync u_sync (.clk(clk), .rst_n(rst_n), .async_in(src_clk[s]),
                     .rise(s_rise[s]), .fall(s_fall[s]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= {NCH{SEL_OFF}};
      div_q <= '0;
    end else begin
      if (cmd_valid && int'(cmd_ch) < NCH) begin
        if (cmd_off)                sel_q[cmd_ch] <= SEL_OFF;
        else if (cmd_src != SEL_OFF) sel_q[cmd_ch] <= cmd_src;
      end
      if (reg_wr && rg_div && int'(rg_ch) < NCH)
        div_q[rg_src][rg_ch] <= reg_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < NSRC; s++)
        ch_fields[c][s] = div_q[s][c];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tcb_channel u_ch (
      .clk(clk), .rst_n(rst_n), .rise(s_rise), .fall(s_fall),
      .fields(ch_fields[c]), .target(sel_q[c]),
      .ch_out(ch_clk[c]), .run(run_m[c])
    );
  end

  always_comb begin
    sel_w0 = '0;
    sel_w1 = '0;
    fb_w   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_pos(SEL_LSB, c) < 32) begin
        sel_w0[sel_pos(SEL_LSB, c)]     = sel_q[c][0];
        sel_w0[sel_pos(SEL_LSB, c) + 1] = sel_q[c][1];
      end else begin
        sel_w1[sel_pos(SEL_LSB, c) - 32] = sel_q[c][0];
        sel_w1[sel_pos(SEL_LSB, c) - 31] = sel_q[c][1];
      end
      for (int s = 0; s < NSRC; s++)
        fb_w[s][FB_LSB + c] = run_m[c][s];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rg_div) begin
      if (int'(rg_ch) < NCH) reg_rdata[DIV_W-1:0] = div_q[rg_src][rg_ch];
    end else begin
      case (rg_ch)
        4'd0: reg_rdata = sel_w0;
        4'd1: reg_rdata = sel_w1;
        4'd2: reg_rdata = fb_w[0];
        4'd3: reg_rdata = fb_w[1];
        4'd4: reg_rdata = fb_w[2];
        default: reg_rdata = '0;
      endcase
    end
  end

  // A source request of code 3 must not touch any select field
  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_off && cmd_src == SEL_OFF) |=> $stable(sel_q));
endmodule

// File: tb/tri_src_clk_bank_bench.sv
`timescale 1ns/1ps
module tri_src_clk_bank_bench;
  localparam int NCH = 14;
  localparam int FBL = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  src_clk = 3'b000;
  logic        cmd_valid, cmd_off;
  logic [3:0]  cmd_ch;
  logic [1:0]  cmd_src;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NCH-1:0] ch_clk;

  int checks = 0, fails = 0, cyc = 0, runts = 0;
  int hlen [NCH];
  int tsrc [3] = '{4, 6, 10};

  tri_src_clk_bank u_tri_src_clk_bank (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .cmd_valid(cmd_valid),
    .cmd_ch(cmd_ch), .cmd_off(cmd_off), .cmd_src(cmd_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_clk(ch_clk)
  );

  always #2.5 clk = ~clk;
  initial begin #1; forever #10 src_clk[0] = ~src_clk[0]; end
  initial begin #1; forever #15 src_clk[1] = ~src_clk[1]; end
  initial begin #1; forever #25 src_clk[2] = ~src_clk[2]; end
  always @(posedge clk) cyc <= cyc + 1;

  // High pulses shorter than the smallest source half period (2 cycles)
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) hlen[c] = 0;
      else if (ch_clk[c]) hlen[c]++;
      else begin
        if (hlen[c] > 0 && hlen[c] < 2) runts++;
        hlen[c] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cmd(input int ch, input bit off, input int src);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ch = 4'(ch); cmd_off = off; cmd_src = 2'(src);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_level(input int ch, input logic v, output bit ok);
    int n = 0;
    ok = 1'b1;
    while (ch_clk[ch] !== v) begin
      @(negedge clk);
      n++;
      if (n > 1500) begin ok = 1'b0; return; end
    end
  endtask

  task automatic measure(input int ch, output int per, output int hi, output bit ok);
    int t0, t1;
    bit k;
    ok = 1'b1; per = 0; hi = 0;
    wait_level(ch, 1'b0, k); ok &= k;
    wait_level(ch, 1'b1, k); ok &= k;
    wait_level(ch, 1'b0, k); ok &= k;
    wait_level(ch, 1'b1, k); ok &= k;
    t0 = cyc;
    wait_level(ch, 1'b0, k); ok &= k;
    t1 = cyc;
    wait_level(ch, 1'b1, k); ok &= k;
    per = cyc - t0; hi = t1 - t0;
  endtask

  task automatic wait_fb(input int s, input int ch, output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      rd(2 + s, d);
      if (d[FBL + ch]) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic check_rate(input int ch, input int s, input int f, input string tag);
    int per, hi, exp_hi;
    bit ok;
    measure(ch, per, hi, ok);
    exp_hi = (f == 0) ? tsrc[s] / 2 : ((f + 1) / 2) * tsrc[s];
    chk(ok && per == (f + 1) * tsrc[s], {tag, " R4 period"}, per, (f + 1) * tsrc[s]);
    chk(ok && hi == exp_hi, {tag, " R5 high time"}, hi, exp_hi);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_off = 1'b0; cmd_ch = '0; cmd_src = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state; R2 field positions with all fields at 3
    rd(0, d); chk(d == 32'hFFFFFF00, "R1 R2 select word 0", d, 32'hFFFFFF00);
    rd(1, d); chk(d == 32'h0000000F, "R1 R2 select word 1", d, 32'h0000000F);
    for (int s = 0; s < 3; s++) begin
      rd(2 + s, d); chk(d == 0, "R1 status word", d, 0);
    end
    rd(16, d); chk(d == 0, "R1 divider field", d, 0);
    chk(ch_clk == '0, "R1 outputs low", ch_clk, 0);

    // R3 divider word decode and masking
    wr(16 + 16 * 1 + 5, 32'hFFFFFFEA);
    rd(16 + 16 * 1 + 5, d); chk(d == 32'h0A, "R3 masked readback", d, 32'h0A);
    wr(16 + 16 * 2 + 13, 32'h13);
    rd(16 + 16 * 2 + 13, d); chk(d == 32'h13, "R3 last channel slot", d, 32'h13);
    wr(16 + 15, 32'h1F);
    rd(16 + 15, d); chk(d == 0, "R3 slot above NCH", d, 0);
    rd(16 + 5, d); chk(d == 0, "R3 neighbour untouched", d, 0);
    wr(16 + 16 * 1 + 5, 0);
    wr(16 + 16 * 2 + 13, 0);

    // R2 spill into second select word
    cmd(12, 1'b0, 1);
    rd(1, d); chk(d == 32'h0000000D, "R2 channel 12 in word 1", d, 32'h0000000D);
    cmd(11, 1'b0, 2);
    rd(0, d); chk(d == 32'hBFFFFF00, "R2 channel 11 at word 0 top", d, 32'hBFFFFF00);
    cmd(12, 1'b1, 0);
    cmd(11, 1'b1, 0);
    rd(0, d); chk(d == 32'hFFFFFF00, "R7 off restores word 0", d, 32'hFFFFFF00);
    rd(1, d); chk(d == 32'h0000000F, "R7 off restores word 1", d, 32'h0000000F);

    // R6 rejected source code on an off channel
    cmd(0, 1'b0, 3);
    rd(0, d); chk(d == 32'hFFFFFF00, "R6 code 3 rejected", d, 32'hFFFFFF00);

    // R4 R5 R8 full divider sweep on channel 0 for every source
    for (int s = 0; s < 3; s++) begin
      wr(16 + 16 * s, 0);
      cmd(0, 1'b0, s);
      repeat (2) @(negedge clk);
      for (int o = 0; o < 3; o++) begin
        rd(2 + o, d);
        if (o != s) chk(d[FBL] == 1'b0, "R8 other source clear", d[FBL], 0);
      end
      wait_fb(s, 0, ok);
      chk(ok, "R8 running bit sets", ok, 1);
      for (int f = 0; f < 32; f++) begin
        wr(16 + 16 * s, f);
        check_rate(0, s, f, "sweep");
      end
    end

    // R9 change source while running: ch0 on src2 -> src0 field 3
    wr(16, 3);
    cmd(0, 1'b0, 0);
    @(negedge clk);
    rd(4, d); chk(d[FBL] == 1'b0, "R9 old status clears", d[FBL], 0);
    wait_fb(0, 0, ok);
    chk(ok, "R9 new status sets", ok, 1);
    rd(2, d); chk(d == (32'h1 << FBL), "R9 status word bit position", d, 32'h1 << FBL);
    check_rate(0, 0, 3, "R9 after change");

    // R6 rejection on a running channel
    cmd(0, 1'b0, 3);
    rd(0, d); chk(d[9:8] == 2'd0, "R6 field kept", d[9:8], 0);
    check_rate(0, 0, 3, "R6 still running");

    // R7 switch-off
    cmd(0, 1'b1, 0);
    repeat (40) @(negedge clk);
    rd(0, d); chk(d[9:8] == 2'd3, "R7 field reads 3", d[9:8], 3);
    rd(2, d); chk(d == 0, "R7 status cleared", d, 0);
    ok = 1'b1;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (ch_clk[0]) ok = 1'b0;
    end
    chk(ok, "R7 output stays low", ok, 1);

    // R10 burst of switches on channel 13, then settle
    wr(16 + 13, 1);
    wr(16 + 16 + 13, 0);
    wr(16 + 32 + 13, 2);
    for (int i = 0; i < 24; i++) begin
      cmd(13, (i % 5) == 4, i % 3);
      repeat (i % 4) @(negedge clk);
    end
    cmd(13, 1'b0, 1);
    wait_fb(1, 13, ok);
    chk(ok, "R8 channel 13 status", ok, 1);
    rd(3, d); chk(d == (32'h1 << (FBL + 13)), "R8 channel 13 bit", d, 32'h1 << (FBL + 13));
    check_rate(13, 1, 0, "R10 settled");
    cmd(13, 1'b0, 2);
    wait_fb(2, 13, ok);
    chk(ok, "R9 channel 13 moved", ok, 1);
    check_rate(13, 2, 2, "R10 moved");
    chk(runts == 0, "R10 no runt high pulses", runts, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule